// File: doc/BRIEF.md
# Exclusive Last-Level Cache Coherence Grant Unit

This unit answers coherence requests that a child cache sends to an exclusive last-level cache. The last level and the caches beneath it never hold the same line at once, so the unit keeps no record of sharers. It decides the granted child state from a handful of flags that arrive with each request: whether the line was found in this cache, whether a copy lives somewhere in the inner levels, whether the request is a prefetch, and whether the parent holds the line exclusively.

When a copy must be taken away from other inner caches, the unit sends one broadcast to every child except the requester. The broadcast either invalidates those copies or downgrades them to shared. It then waits until every addressed child has acknowledged before it sends the response. While it waits it refuses new requests. Illegal requests get an error response that carries the child state back unchanged.

Top module: `exllc_coh_resp`

## Requirements
- R1: After reset `resp_valid` and `inv_valid` are low and `req_ready` is high.
- R2: On a miss with no inner copy, a read (kind 0) is granted E (state code 2) and a write (kind 1) is granted M (code 3). No broadcast is sent, and `resp_valid` rises in the cycle after acceptance.
- R3: On a miss with an inner copy, a read sends a downgrade broadcast (`inv_invx`=1) and is granted S (code 1).
- R4: On a miss with an inner copy, a write sends an invalidate broadcast (`inv_invx`=0) and is granted M. On a miss the prefetch flag has no effect.
- R5: A broadcast addresses every child except the requester: bit `req_child` of `inv_targets` is 0 and every other bit is 1.
- R6: The response comes one cycle after the last addressed child acknowledges on `inv_ack`. Acknowledgements from children that were not addressed are ignored.
- R7: On a hit, a release (kind 2 clean, kind 3 dirty) is granted I (code 0) without a broadcast. The inner-copy flag is ignored on a hit.
- R8: On a hit, a read from a child in I is granted E. With the prefetch flag set, the child state is returned unchanged.
- R9: On a hit, a write with the parent exclusive is granted M. With the prefetch flag set, the child state is returned unchanged.
- R10: Each of these sets `resp_error`, sends no broadcast and returns `child_state` unchanged: kind codes 4 to 7, a release on a miss, a hit write without parent exclusivity, and a non-prefetch hit read from a child not in I.
- R11: While acknowledgements are pending, `req_ready` is low and requests on `req_valid` are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_kind | input | 3 | 0 read, 1 write, 2 clean release, 3 dirty release, others illegal |
| req_child | input | IDW | Requesting child index |
| line_hit | input | 1 | Line present in this cache |
| inner_copy | input | 1 | A copy exists in some inner cache |
| prefetch | input | 1 | Request is a prefetch |
| parent_excl | input | 1 | This cache holds the line exclusively |
| child_state | input | 2 | Current child state (0 I, 1 S, 2 E, 3 M) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_state | output | 2 | Granted child state |
| resp_error | output | 1 | Request was illegal |
| inv_valid | output | 1 | One-cycle broadcast strobe |
| inv_invx | output | 1 | 1 downgrade to S, 0 invalidate |
| inv_targets | output | NCHILD | Children addressed by the broadcast |
| inv_ack | input | NCHILD | Per-child acknowledgement |

## Verification
A wrong grant decision shows up on `resp_state` or `resp_error` in the cycle after acceptance, or at the last acknowledgement. A wrong broadcast decision shows up one cycle after acceptance, as a `inv_valid` strobe that should not be there or one that is missing. A damaged pending-acknowledge record shows up as a response that comes too early, or as `req_ready` stuck low until the watchdog fires. Partial acknowledgements and stray acknowledgements from the requester are therefore driven one cycle at a time, and the outputs are sampled after each one.

// File: rtl/exllc_pkg.sv
package exllc_pkg;

  localparam logic [2:0] K_READ  = 3'd0;
  localparam logic [2:0] K_WRITE = 3'd1;
  localparam logic [2:0] K_RELC  = 3'd2;
  localparam logic [2:0] K_RELD  = 3'd3;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } cstate_e;

  typedef struct packed {
    logic       err;
    logic       bcast;
    logic       invx;
    logic [1:0] grant;
  } verdict_t;

  function automatic verdict_t judge(
    input logic [2:0] kind,
    input logic       hit,
    input logic       inner,
    input logic       pf,
    input logic       pexcl,
    input logic [1:0] cin
  );
    verdict_t v;
    v.err   = 1'b0;
    v.bcast = 1'b0;
    v.invx  = 1'b0;
    v.grant = cin;
    case (kind)
      K_READ: begin
        if (!hit) begin
          if (inner) begin
            v.bcast = 1'b1;
            v.invx  = 1'b1;
            v.grant = ST_S;
          end else begin
            v.grant = ST_E;
          end
        end else if (pf) begin
          v.grant = cin;
        end else if (cin != ST_I) begin
          v.err = 1'b1;
        end else begin
          v.grant = ST_E;
        end
      end
      K_WRITE: begin
        if (!hit) begin
          v.bcast = inner;
          v.grant = ST_M;
        end else if (!pexcl) begin
          v.err = 1'b1;
        end else if (!pf) begin
          v.grant = ST_M;
        end
      end
      K_RELC, K_RELD: begin
        if (!hit) v.err = 1'b1;
        else      v.grant = ST_I;
      end
      default: v.err = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/exllc_decide.sv
module exllc_decide
  import exllc_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       hit,
  input  logic       inner,
  input  logic       pf,
  input  logic       pexcl,
  input  logic [1:0] cin,
  output verdict_t   verdict
);
  always_comb verdict = judge(kind, hit, inner, pf, pexcl, cin);
endmodule

// File: rtl/exllc_target_mask.sv
module exllc_target_mask #(
  parameter int NCHILD = 4,
  localparam int IDW = (NCHILD > 1) ? $clog2(NCHILD) : 1
) (
  input  logic [IDW-1:0]    self_id,
  output logic [NCHILD-1:0] others
);
  for (genvar g = 0; g < NCHILD; g++) begin : g_bit
    assign others[g] = (self_id != IDW'(g));
  end
endmodule

// File: rtl/exllc_ack_track.sv
module exllc_ack_track #(
  parameter int NCHILD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [NCHILD-1:0] launch_mask,
  input  logic [NCHILD-1:0] ack,
  output logic              done
);
  logic [NCHILD-1:0] pending;
  logic [NCHILD-1:0] remaining;

  assign remaining = pending & ~ack;
  assign done      = (|pending) && (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= '0;
    else if (launch) pending <= launch_mask;
    else             pending <= remaining;
  end

  // R6: outside a launch the pending set can only shrink
  a_r6_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/exllc_coh_resp.sv
module exllc_coh_resp
  import exllc_pkg::*;
#(
  parameter int NCHILD = 4,
  localparam int IDW = (NCHILD > 1) ? $clog2(NCHILD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [IDW-1:0]    req_child,
  input  logic              line_hit,
  input  logic              inner_copy,
  input  logic              prefetch,
  input  logic              parent_excl,
  input  logic [1:0]        child_state,
  output logic              resp_valid,
  output logic [1:0]        resp_state,
  output logic              resp_error,
  output logic              inv_valid,
  output logic              inv_invx,
  output logic [NCHILD-1:0] inv_targets,
  input  logic [NCHILD-1:0] inv_ack
);
  verdict_t          verdict;
  logic [NCHILD-1:0] others;
  logic              accept;
  logic              launch;
  logic              trk_done;
  logic              waiting;
  logic [IDW-1:0]    req_id_q;

  exllc_decide u_decide (
    .kind    (req_kind),
    .hit     (line_hit),
    .inner   (inner_copy),
    .pf      (prefetch),
    .pexcl   (parent_excl),
    .cin     (child_state),
    .verdict (verdict)
  );

  exllc_target_mask #(.NCHILD(NCHILD)) u_mask (
    .self_id (req_child),
    .others  (others)
  );

  assign req_ready = !waiting;
  assign accept    = req_valid && req_ready;
  assign launch    = accept && verdict.bcast && (|others);

  exllc_ack_track #(.NCHILD(NCHILD)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_mask (others),
    .ack         (inv_ack),
    .done        (trk_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting     <= 1'b0;
      resp_valid  <= 1'b0;
      resp_state  <= ST_I;
      resp_error  <= 1'b0;
      inv_valid   <= 1'b0;
      inv_invx    <= 1'b0;
      inv_targets <= '0;
      req_id_q    <= '0;
    end else begin
      resp_valid <= 1'b0;
      inv_valid  <= 1'b0;
      if (accept) begin
        resp_state <= verdict.grant;
        resp_error <= verdict.err;
        req_id_q   <= req_child;
        if (launch) begin
          waiting     <= 1'b1;
          inv_valid   <= 1'b1;
          inv_invx    <= verdict.invx;
          inv_targets <= others;
        end else begin
          resp_valid <= 1'b1;
        end
      end else if (waiting && trk_done) begin
        waiting    <= 1'b0;
        resp_valid <= 1'b1;
      end
    end
  end

  // R2, R6: every accepted request yields exactly one of response or broadcast next cycle
  a_r2_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (resp_valid ^ inv_valid));

  // R6: no response while acknowledgements are still outstanding
  a_r6_no_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !trk_done) |=> !resp_valid);

  // R5: the requester is never addressed by its own broadcast
  a_r5_requester_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !inv_targets[req_id_q]);

  // R3: a downgrade broadcast is paired with a shared grant
  a_r3_invx_grants_s: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_invx) |-> (resp_state == ST_S));

  // R10: an illegal request never broadcasts and answers with an error
  a_r10_err_no_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && verdict.err) |=> (!inv_valid && resp_valid && resp_error));

  // R7: a release that hits is answered with I and no error
  a_r7_release_to_i: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && line_hit && (req_kind == K_RELC || req_kind == K_RELD))
      |=> (resp_state == ST_I && !resp_error && !inv_valid));
endmodule

// File: tb/exllc_coh_resp_test.sv
`timescale 1ns/1ps
module exllc_coh_resp_test;
  localparam int N   = 4;
  localparam int IDW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [2:0]     req_kind = '0;
  logic [IDW-1:0] req_child = '0;
  logic           line_hit = 1'b0, inner_copy = 1'b0, prefetch = 1'b0, parent_excl = 1'b0;
  logic [1:0]     child_state = '0;
  logic           resp_valid, resp_error, inv_valid, inv_invx;
  logic [1:0]     resp_state;
  logic [N-1:0]   inv_targets;
  logic [N-1:0]   inv_ack = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  exllc_coh_resp #(.NCHILD(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_child(req_child), .line_hit(line_hit),
    .inner_copy(inner_copy), .prefetch(prefetch), .parent_excl(parent_excl),
    .child_state(child_state), .resp_valid(resp_valid), .resp_state(resp_state),
    .resp_error(resp_error), .inv_valid(inv_valid), .inv_invx(inv_invx),
    .inv_targets(inv_targets), .inv_ack(inv_ack)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic       hit, inner, pf, pexcl;
    logic [1:0] cin;
    logic [1:0] id;
    logic       e_err, e_bc, e_invx;
    logic [1:0] e_st;
  } tv_t;

  // kind hit inner pf pexcl cin id | err bc invx state
  localparam int NV = 16;
  localparam tv_t TV [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2},
    '{3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3},
    '{3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 2'd1},
    '{3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3},
    '{3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd3},
    '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2},
    '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1},
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3},
    '{3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0},
    '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2},
    '{3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1},
    '{3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3},
    '{3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0}
  };

  function automatic string tag_of(tv_t v);
    if (v.e_err)                 return "R10";
    if (!v.hit && !v.inner)      return "R2";
    if (!v.hit && v.kind == 3'd0) return "R3";
    if (!v.hit)                  return "R4";
    if (v.kind >= 3'd2)          return "R7";
    if (v.kind == 3'd0)          return "R8";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  function automatic logic [N-1:0] others_of(logic [1:0] id);
    return {N{1'b1}} & ~(N'(1) << id);
  endfunction

  task automatic drive(tv_t v);
    req_kind = v.kind; line_hit = v.hit; inner_copy = v.inner; prefetch = v.pf;
    parent_excl = v.pexcl; child_state = v.cin; req_child = v.id;
  endtask

  task automatic run_vec(tv_t v);
    string t;
    logic [N-1:0] m;
    t = tag_of(v);
    m = others_of(v.id);
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.e_bc) begin
      check(inv_valid === 1'b1, t, "inv_valid", int'(inv_valid), 1);
      check(inv_invx === v.e_invx, t, "inv_invx", int'(inv_invx), int'(v.e_invx));
      check(inv_targets === m, "R5", "inv_targets", int'(inv_targets), int'(m));
      check(resp_valid === 1'b0, "R6", "resp before ack", int'(resp_valid), 0);
      inv_ack = m;
      @(negedge clk);
      inv_ack = '0;
    end else begin
      check(inv_valid === 1'b0, t, "inv_valid", int'(inv_valid), 0);
    end
    check(resp_valid === 1'b1, t, "resp_valid", int'(resp_valid), 1);
    check(resp_state === v.e_st, t, "resp_state", int'(resp_state), int'(v.e_st));
    check(resp_error === v.e_err, t, "resp_error", int'(resp_error), int'(v.e_err));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(resp_valid === 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
    check(inv_valid === 1'b0, "R1", "inv_valid", int'(inv_valid), 0);
    check(req_ready === 1'b1, "R1", "req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(resp_valid === 1'b0 && inv_valid === 1'b0, "R1", "idle after reset",
          int'({resp_valid, inv_valid}), 0);

    for (int i = 0; i < NV; i++) run_vec(TV[i]);

    // R6 and R11: partial and stray acknowledgements, request while busy
    @(negedge clk);
    drive('{3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3});
    req_valid = 1'b1;
    @(negedge clk);
    check(inv_targets === 4'b1101, "R5", "targets id1", int'(inv_targets), 13);
    check(req_ready === 1'b0, "R11", "ready while waiting", int'(req_ready), 0);
    inv_ack = 4'b0010;  // requester itself: must be ignored
    drive('{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2});
    @(negedge clk);
    check(resp_valid === 1'b0, "R6", "stray ack", int'(resp_valid), 0);
    inv_ack = 4'b0001;
    @(negedge clk);
    check(resp_valid === 1'b0, "R6", "partial ack", int'(resp_valid), 0);
    check(req_ready === 1'b0, "R11", "still waiting", int'(req_ready), 0);
    inv_ack = 4'b1100;
    req_valid = 1'b0;
    @(negedge clk);
    inv_ack = '0;
    check(resp_valid === 1'b1, "R6", "resp after last ack", int'(resp_valid), 1);
    check(resp_state === 2'd3, "R4", "grant held across wait", int'(resp_state), 3);
    @(negedge clk);
    check(resp_valid === 1'b0 && inv_valid === 1'b0, "R11", "busy request not served",
          int'({resp_valid, inv_valid}), 0);
    check(req_ready === 1'b1, "R11", "ready again", int'(req_ready), 1);

    // R2: back-to-back requests, one response per cycle
    @(negedge clk);
    drive('{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2});
    req_valid = 1'b1;
    @(negedge clk);
    check(resp_valid === 1'b1 && resp_state === 2'd2, "R2", "first of pair",
          int'(resp_state), 2);
    req_kind = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid === 1'b1 && resp_state === 2'd3, "R2", "second of pair",
          int'(resp_state), 3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule